// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds a small set of recent virtual-to-physical page translations and answers a lookup in the same cycle it is presented. Every stored translation is compared against the request in parallel; a translation only counts when both its virtual page number and its address-space tag equal the request. A hit yields the physical page number together with the entry's bookkeeping flags: whether the page has been touched, and whether it has been modified.

The block maintains those flags itself. A lookup that succeeds marks the entry as touched. A successful store marks it as modified. A store aimed at a page whose rights allow reading only is reported as a protection fault and leaves the entry untouched.

New translations arrive on a separate fill port, normally from a page walker outside this block. A fill takes a free slot when one exists and otherwise evicts the slot named by a rotating pointer. A single-cycle flush drops every translation at once.

Top module: `tlb_xlate`

## Requirements
- R1: With `lk_valid` high, `lk_hit` is 1 in the same cycle when a valid entry has the request's virtual page and tag; `lk_ppn` then carries that entry's physical page.
- R2: An entry whose tag differs from `lk_asid` never hits, even when its virtual page matches.
- R3: When `lk_hit` is 0 (miss or `lk_valid` low), `lk_ppn`, `lk_ref`, `lk_dirty` and `lk_fault` are all 0. On a hit, `lk_ref` and `lk_dirty` show the entry's flags as they stood before this lookup.
- R4: A lookup that hits without a fault sets the entry's touched flag, visible on the next hit of that entry.
- R5: A store lookup (`lk_write`=1) that hits without a fault also sets the entry's modified flag.
- R6: A store hitting an entry filled with `fill_writable`=0 gives `lk_hit`=1 and `lk_fault`=1 and changes neither flag of that entry; a load of such an entry does not fault.
- R7: A fill stores page, tag, physical page and rights with both flags cleared, into the lowest-numbered invalid slot when any slot is invalid.
- R8: With every slot valid, a fill replaces the slot named by a rotating pointer that is 0 after reset, steps by one (wrapping after the last slot) only on such fills, and is left alone by flushes and by fills into free slots.
- R9: `flush` invalidates every slot at the next edge; a fill or a flag update in the same cycle is dropped.
- R10: After reset every slot is invalid and the rotating pointer is 0.
- R11: When a fill and a hitting lookup name the same slot in one cycle, the fill wins: the new translation starts with both flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Drop all translations |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_asid | input | ASID_W | Address-space tag of the request |
| lk_write | input | 1 | 1 = store, 0 = load |
| lk_hit | output | 1 | Translation found |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_ref | output | 1 | Touched flag of the hit entry |
| lk_dirty | output | 1 | Modified flag of the hit entry |
| lk_fault | output | 1 | Store to a read-only page |
| fill_valid | input | 1 | Install a new translation |
| fill_vpn | input | VPN_W | Virtual page to install |
| fill_asid | input | ASID_W | Tag to install |
| fill_ppn | input | PPN_W | Physical page to install |
| fill_writable | input | 1 | 1 = read/write, 0 = read only |

## Verification
The bench sweeps every stored page against every tag and both access kinds, twice, so a design that ignores the tag would hit on foreign tags, and one that forgets to set the touched or modified flag shows a stale flag on the second pass. Stores to read-only pages are checked for a fault with unchanged flags; a design that dirtied them would show the flag on a later load. Replacement is driven past the pointer wrap and across a flush, so a pointer that reset on flush or advanced on free-slot fills would evict the wrong page. Same-cycle fill with hit and fill with flush are hit directly, exposing a wrong priority as leftover flags or a surviving entry.

// File: rtl/tlb_pkg.sv
// Shared types for the translation cache.
// Assumes nothing beyond the users agreeing on the flag layout.
package tlb_pkg;
    typedef struct packed {
        logic valid;
        logic writable;
        logic referenced;
        logic dirty;
    } tlb_flags_t;
endpackage

// File: rtl/tlb_match.sv
// Parallel tag comparator: compares one key against every slot and
// encodes the hitting slot. Assumes at most one slot matches a key
// (the filler never installs a duplicate page/tag pair).
module tlb_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] slot_valid,
    input  logic [VPN_W-1:0]   slot_vpn  [ENTRIES],
    input  logic [ASID_W-1:0]  slot_asid [ENTRIES],
    input  logic [VPN_W-1:0]   key_vpn,
    input  logic [ASID_W-1:0]  key_asid,
    output logic               any_hit,
    output logic [IDX_W-1:0]   hit_idx
);
    logic [ENTRIES-1:0] match;

    // One comparator per slot, page and tag both qualified by valid.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = slot_valid[g] && (slot_vpn[g] == key_vpn)
                          && (slot_asid[g] == key_asid);
    end

    // Encode the matching slot; lowest index wins if ever several match.
    always_comb begin
        hit_idx = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (match[k]) hit_idx = IDX_W'(k);
        end
    end

    assign any_hit = |match;

    // R1
    match_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/tlb_victim.sv
// Replacement chooser: picks the lowest free slot, otherwise the slot
// under a rotating pointer. The pointer moves only when a fill lands
// on it. Assumes fill_go is already masked by flush.
module tlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] slot_valid,
    input  logic               fill_go,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Lowest-numbered invalid slot.
    always_comb begin
        free_idx = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (!slot_valid[k]) free_idx = IDX_W'(k);
        end
    end

    assign any_free   = ~&slot_valid;
    assign victim_idx = any_free ? free_idx : ptr_q;

    // Rotating pointer, stepped only by evicting fills.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (fill_go && !any_free)
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end

    // R7
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_free |-> !slot_valid[victim_idx]);

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_go || any_free) |=> $stable(ptr_q));
endmodule

// File: rtl/tlb_xlate.sv
// Fully associative translation cache with address-space tags.
// Lookup is combinational from stored state; flag updates and fills
// take effect at the next edge. Priority per slot: flush, fill, flag
// update. Assumes the filler never installs a page/tag pair that is
// already present, and ENTRIES is at least 2.
module tlb_xlate #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 16,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_ref,
    output logic              lk_dirty,
    output logic              lk_fault,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_writable
);
    import tlb_pkg::*;

    logic [VPN_W-1:0]   vpn_q   [ENTRIES];
    logic [ASID_W-1:0]  asid_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q   [ENTRIES];
    tlb_flags_t         flags_q [ENTRIES];
    logic [ENTRIES-1:0] valid_vec;
    logic               any_hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   victim_idx;
    logic               fill_go;
    logic               lk_ok;
    tlb_flags_t         hit_flags;

    // Collect the valid bits for the comparator and the chooser.
    always_comb begin
        for (int k = 0; k < ENTRIES; k++) valid_vec[k] = flags_q[k].valid;
    end

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
        .clk(clk), .rst_n(rst_n), .slot_valid(valid_vec),
        .slot_vpn(vpn_q), .slot_asid(asid_q),
        .key_vpn(lk_vpn), .key_asid(lk_asid),
        .any_hit(any_hit), .hit_idx(hit_idx)
    );

    assign fill_go = fill_valid && !flush;

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .slot_valid(valid_vec),
        .fill_go(fill_go), .victim_idx(victim_idx)
    );

    // Drive the lookup outputs, zero on a miss.
    always_comb begin
        hit_flags = flags_q[hit_idx];
        lk_hit    = lk_valid && any_hit;
        lk_fault  = lk_hit && lk_write && !hit_flags.writable;
        lk_ppn    = lk_hit ? ppn_q[hit_idx] : '0;
        lk_ref    = lk_hit && hit_flags.referenced;
        lk_dirty  = lk_hit && hit_flags.dirty;
        lk_ok     = lk_hit && !lk_fault;
    end

    // Slot storage: flush, then fill, then flag update on a good hit.
    always_ff @(posedge clk) begin
        for (int k = 0; k < ENTRIES; k++) begin
            if (!rst_n) begin
                vpn_q[k]   <= '0;
                asid_q[k]  <= '0;
                ppn_q[k]   <= '0;
                flags_q[k] <= '0;
            end else if (flush) begin
                flags_q[k].valid <= 1'b0;
            end else if (fill_go && victim_idx == IDX_W'(k)) begin
                vpn_q[k]   <= fill_vpn;
                asid_q[k]  <= fill_asid;
                ppn_q[k]   <= fill_ppn;
                flags_q[k] <= '{valid: 1'b1, writable: fill_writable,
                                referenced: 1'b0, dirty: 1'b0};
            end else if (lk_ok && hit_idx == IDX_W'(k)) begin
                flags_q[k].referenced <= 1'b1;
                if (lk_write) flags_q[k].dirty <= 1'b1;
            end
        end
    end

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

    // R4
    ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_ok && !flush && !(fill_go && victim_idx == hit_idx))
        |=> flags_q[$past(hit_idx)].referenced);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot_chk
        // R6
        ro_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[g].valid && !flags_q[g].writable) |-> !flags_q[g].dirty);
        // R5
        dirty_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_q[g].dirty) |-> $past(lk_valid && lk_write && !lk_fault));
    end
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
    localparam int N = 8;
    localparam int VW = 20;
    localparam int PW = 16;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic lk_valid = 1'b0, lk_write = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asid = '0;
    logic lk_hit, lk_ref, lk_dirty, lk_fault;
    logic [PW-1:0] lk_ppn;
    logic fill_valid = 1'b0, fill_writable = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [AW-1:0] fill_asid = '0;
    logic [PW-1:0] fill_ppn = '0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Requirement-level model of the slots.
    bit          m_v [N];
    bit          m_w [N];
    bit          m_r [N];
    bit          m_d [N];
    logic [VW-1:0] m_vpn [N];
    logic [AW-1:0] m_asid [N];
    logic [PW-1:0] m_ppn [N];
    int          m_ptr;

    always #2 clk = ~clk;

    tlb_xlate u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_ref(lk_ref), .lk_dirty(lk_dirty),
        .lk_fault(lk_fault), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_asid(fill_asid), .fill_ppn(fill_ppn), .fill_writable(fill_writable)
    );

    task automatic cmp(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, check outputs before the edge, advance the model.
    task automatic step(input bit lv, input logic [VW-1:0] v, input logic [AW-1:0] a,
                        input bit wr, input bit fv, input logic [VW-1:0] fvpn,
                        input logic [AW-1:0] fa, input logic [PW-1:0] fp,
                        input bit fw, input bit fl, input string req);
        bit eh, ef;
        int ek, vic;
        @(negedge clk);
        lk_valid = lv; lk_vpn = v; lk_asid = a; lk_write = wr;
        fill_valid = fv; fill_vpn = fvpn; fill_asid = fa; fill_ppn = fp;
        fill_writable = fw; flush = fl;
        #1;
        eh = 0; ek = 0;
        for (int k = 0; k < N; k++)
            if (lv && m_v[k] && m_vpn[k] == v && m_asid[k] == a) begin eh = 1; ek = k; end
        ef = eh && wr && !m_w[ek];
        if (lv) begin
            cmp(req, "hit", lk_hit, eh);
            cmp(req, "ppn", lk_ppn, eh ? m_ppn[ek] : 0);
            cmp(req, "ref", lk_ref, eh ? m_r[ek] : 0);
            cmp(req, "dirty", lk_dirty, eh ? m_d[ek] : 0);
            cmp(req, "fault", lk_fault, ef);
        end
        if (fl) begin
            for (int k = 0; k < N; k++) m_v[k] = 0;
        end else begin
            if (eh && !ef) begin m_r[ek] = 1; if (wr) m_d[ek] = 1; end
            if (fv) begin
                vic = -1;
                for (int k = N - 1; k >= 0; k--) if (!m_v[k]) vic = k;
                if (vic < 0) begin vic = m_ptr; m_ptr = (m_ptr + 1) % N; end
                m_v[vic] = 1; m_w[vic] = fw; m_r[vic] = 0; m_d[vic] = 0;
                m_vpn[vic] = fvpn; m_asid[vic] = fa; m_ppn[vic] = fp;
            end
        end
    endtask

    task automatic look(input logic [VW-1:0] v, input logic [AW-1:0] a, input bit wr, input string req);
        step(1, v, a, wr, 0, '0, '0, '0, 0, 0, req);
    endtask

    task automatic fill(input logic [VW-1:0] v, input bit fw, input string req);
        step(0, '0, '0, 0, 1, v, AW'(v % 3), PW'(v * 3 + 7), fw, 0, req);
    endtask

    // Look up a range of pages with their own tag, loads then stores.
    task automatic sweep(input int base, input int cnt, input string req);
        for (int i = 0; i < cnt; i++) look(VW'(base + i), AW'((base + i) % 3), 0, req);
        for (int i = 0; i < cnt; i++) look(VW'(base + i), AW'((base + i) % 3), 1, req);
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin
            m_v[k] = 0; m_w[k] = 0; m_r[k] = 0; m_d[k] = 0;
            m_vpn[k] = '0; m_asid[k] = '0; m_ppn[k] = '0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R10: nothing valid after reset
        look(VW'('h100), 0, 0, "R10");
        look(VW'('h101), 1, 1, "R10");
        // R7: fill all slots, even ones writable
        for (int i = 0; i < N; i++) fill(VW'('h100 + i), (i % 2) == 0, "R7");
        // R1 R2 R5 R6: every page x every tag x both kinds, twice (R4 second pass)
        for (int pass = 0; pass < 2; pass++)
            for (int i = 0; i < N; i++)
                for (int a = 0; a < 3; a++)
                    for (int w = 0; w < 2; w++) begin
                        string rq;
                        if (a != (('h100 + i) % 3)) rq = "R2";
                        else if (pass == 1) rq = "R4";
                        else if (w == 1 && (i % 2) == 1) rq = "R6";
                        else if (w == 1) rq = "R5";
                        else rq = "R1";
                        look(VW'('h100 + i), AW'(a), bit'(w), rq);
                    end
        // R3: lookup strobe low gives zeros
        step(0, VW'('h100), AW'(1), 0, 0, '0, '0, '0, 0, 0, "R3");
        vectors++;
        if (lk_hit || lk_ppn != 0 || lk_ref || lk_dirty || lk_fault) begin
            miscompares++;
            $display("FAIL R3 idle outputs: actual %0b/%0h expected 0/0", lk_hit, lk_ppn);
        end
        // R8: evicting fills past the pointer wrap
        for (int i = 0; i < N + 3; i++) begin
            fill(VW'('h200 + i), i % 3 != 0, "R8");
            sweep('h100, N, "R8");
            sweep('h200, i + 1, "R8");
        end
        // R9: flush with a fill in the same cycle; fill is dropped
        step(0, '0, '0, 0, 1, VW'('h300), AW'(0), PW'(5), 1, 1, "R9");
        sweep('h200, N + 3, "R9");
        look(VW'('h300), 0, 0, "R9");
        // R8: pointer kept across flush, free fills do not move it
        for (int i = 0; i < N; i++) fill(VW'('h400 + i), 1, "R7");
        fill(VW'('h500), 1, "R8");
        fill(VW'('h501), 0, "R8");
        sweep('h400, N, "R8");
        sweep('h500, 2, "R8");
        // R11: store hit on the slot under the pointer while filling it
        look(VW'('h400 + m_ptr), AW'(('h400 + m_ptr) % 3), 1, "R11");
        step(1, VW'('h400 + m_ptr), AW'(('h400 + m_ptr) % 3), 1,
             1, VW'('h600), AW'('h600 % 3), PW'('h99), 1, 0, "R11");
        look(VW'('h600), AW'('h600 % 3), 0, "R11");
        sweep('h400, N, "R11");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule